// File: doc/BRIEF.md
# Keyed 64-bit Watchdog Timer

This block is a 64-bit up-counting timer with a watchdog mode, reached through a simple 32-bit register bus. The count advances once per prescaler tick while both counter halves are out of reset and continuous run is selected. When the count reaches a 64-bit compare value, it returns to zero.

In watchdog mode, software must service the block regularly. Servicing is an ordered pair of key writes to the watchdog control register. If servicing stops and the count reaches the compare value, the block raises a one-cycle reset request and latches a sticky timeout flag.

The bus is a single-cycle write strobe with a word address. Reads are combinational from the same address.

Register map (word address):
- 0: global control. Holds the counter-half release bits, the mode field and the prescale value.
- 1: run control.
- 2: counter low word.
- 3: counter high word.
- 4: compare low word.
- 5: compare high word.
- 6: watchdog control.
- 7: unused, reads zero.

Top module: `wdog_timer64`

## Requirements
- R1: After reset, every register reads 0 and `wdt_rst` is low. The watchdog enable bit is cleared only by reset.
- R2: Each register reads back only its defined fields, with every other bit reading 0:
  - Global control keeps bits [1:0], [3:2] and [11:8].
  - Run control keeps bits [23:22].
  - The counter and compare words keep all 32 bits. Counter words return the live count.
  - Watchdog control returns the enable bit at bit 14 and the timeout flag at bit 15.
- R3: The count advances only when global control bits [1:0] are both 1 and run control bits [23:22] equal 2. It then steps by one every (global control[11:8] + 1) clocks, for example once every 16 clocks when that field is 15.
- R4: The count is 64 bits wide, and the low word carries into the high word. On a tick where the full 64-bit count equals the 64-bit compare value, the count returns to 0 instead of incrementing.
- R5: Suppose the watchdog is enabled and global control bits [3:2] equal 2. A compare match then drives `wdt_rst` high for exactly one cycle, in the cycle after the matching tick, and sets the timeout flag (bit 15).
- R6: Writing 1 to bit 15 of watchdog control clears the timeout flag. Writing 0 to bit 14 never clears the enable bit.
- R7: A watchdog control write with key 0xA5C6 in bits [31:16] and bit 14 set enables the watchdog and arms the key sequence. If the very next watchdog control write carries 0xDA7E with bit 14 set, it clears all 64 bits of the count. This clear takes priority over a tick in the same cycle.
- R8: Any other watchdog control write leaves the count unchanged and disarms the sequence. This covers a wrong key, 0xDA7E without a preceding arm, and either key written without bit 14. Writes to other registers do not affect the key sequence.
- R9: Repeating the 0xA5C6/0xDA7E pair more often than the compare interval keeps `wdt_rst` low and the flag clear.
- R10: When global control bits [3:2] are not 2, a compare match wraps the count but produces no `wdt_rst` pulse and no flag, even with the watchdog enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| wdt_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions check the following on every cycle:
- `wdt_rst` never stays high for two cycles.
- Every pulse has its flag set and came from watchdog mode.
- The enable bit never falls.
- A valid service always leaves a zero count.
- A plain tick adds exactly one.

Only the bench scenarios can show the following:
- The prescale ratio.
- The carry between words.
- The exact cycle of the timeout.
- That misordered or incomplete key pairs leave the count alone.
- That steady servicing holds off a reset over many intervals.

// File: rtl/wdog_timer64.sv
module wdog_timer64 #(
  parameter int          PSW      = 4,
  parameter logic [15:0] KEY_ARM  = 16'hA5C6,
  parameter logic [15:0] KEY_SVC  = 16'hDA7E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        wdt_rst
);
  localparam logic [2:0] A_GCTL = 3'd0, A_TCTL = 3'd1, A_CLO = 3'd2, A_CHI = 3'd3,
                         A_PLO  = 3'd4, A_PHI  = 3'd5, A_WCTL = 3'd6;
  localparam logic [1:0] MODE_WD = 2'd2, RUN_CONT = 2'd2;
  localparam int         EN_BIT = 14, FLAG_BIT = 15;

  logic [1:0]     rel;
  logic [1:0]     tmode;
  logic [PSW-1:0] div;
  logic [1:0]     run_mode;
  logic [63:0]    cnt, per;
  logic [PSW-1:0] pre;
  logic           wd_en, flag, armed, rst_q;

  logic wr_g, wr_t, wr_cl, wr_ch, wr_pl, wr_ph, wr_w, cnt_wr;
  logic running, tick, hit, key_arm, svc, timeout;

  assign wr_g   = wr_en && addr == A_GCTL;
  assign wr_t   = wr_en && addr == A_TCTL;
  assign wr_cl  = wr_en && addr == A_CLO;
  assign wr_ch  = wr_en && addr == A_CHI;
  assign wr_pl  = wr_en && addr == A_PLO;
  assign wr_ph  = wr_en && addr == A_PHI;
  assign wr_w   = wr_en && addr == A_WCTL;
  assign cnt_wr = wr_cl || wr_ch;

  assign running = (&rel) && run_mode == RUN_CONT;
  assign tick    = running && pre == div;
  assign hit     = tick && cnt == per;
  assign key_arm = wr_w && wdata[EN_BIT] && wdata[31:16] == KEY_ARM;
  assign svc     = wr_w && armed && wdata[EN_BIT] && wdata[31:16] == KEY_SVC;
  assign timeout = hit && wd_en && tmode == MODE_WD && !cnt_wr && !svc;
  assign wdt_rst = rst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel <= '0; tmode <= '0; div <= '0; run_mode <= '0; per <= '0;
    end else begin
      if (wr_g) begin
        rel   <= wdata[1:0];
        tmode <= wdata[3:2];
        div   <= wdata[8 +: PSW];
      end
      if (wr_t)  run_mode    <= wdata[23:22];
      if (wr_pl) per[31:0]   <= wdata;
      if (wr_ph) per[63:32]  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               pre <= '0;
    else if (!running || tick) pre <= '0;
    else                      pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt_wr) begin
      if (wr_cl) cnt[31:0]  <= wdata;
      if (wr_ch) cnt[63:32] <= wdata;
    end
    else if (svc)  cnt <= '0;
    else if (tick) cnt <= hit ? 64'd0 : cnt + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_en <= 1'b0; flag <= 1'b0; armed <= 1'b0; rst_q <= 1'b0;
    end else begin
      rst_q <= timeout;
      if (key_arm) wd_en <= 1'b1;
      if (wr_w)    armed <= key_arm;
      if (timeout)                     flag <= 1'b1;
      else if (wr_w && wdata[FLAG_BIT]) flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_GCTL: begin
        rdata[1:0]     = rel;
        rdata[3:2]     = tmode;
        rdata[8 +: PSW] = div;
      end
      A_TCTL: rdata[23:22] = run_mode;
      A_CLO:  rdata = cnt[31:0];
      A_CHI:  rdata = cnt[63:32];
      A_PLO:  rdata = per[31:0];
      A_PHI:  rdata = per[63:32];
      A_WCTL: begin
        rdata[EN_BIT]   = wd_en;
        rdata[FLAG_BIT] = flag;
      end
      default: rdata = '0;
    endcase
  end

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  assert_pulse_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> flag && wd_en);
  assert_pulse_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(tmode) == MODE_WD);
  assert_enable_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en |=> wd_en);
  assert_service_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && !cnt_wr) |=> cnt == 64'd0);
  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit && !cnt_wr && !svc) |=> cnt == $past(cnt) + 64'd1);
endmodule

// File: tb/sim_wdog_timer64.sv
`timescale 1ns/100ps
module sim_wdog_timer64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst;
  int checks = 0, fails = 0, pulses = 0;

  wdog_timer64 u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst));

  always #2 clk = ~clk;
  always @(negedge clk) if (rst_n && wdt_rst) pulses++;

  // {addr, write data, expected readback}  (R2)
  localparam logic [66:0] VEC [7] = '{
    {3'd2, 32'hDEADBEEF, 32'hDEADBEEF},
    {3'd3, 32'h0BADF00D, 32'h0BADF00D},
    {3'd4, 32'h12345678, 32'h12345678},
    {3'd5, 32'h9ABCDEF0, 32'h9ABCDEF0},
    {3'd1, 32'hFFFFFFFF, 32'h00C00000},
    {3'd0, 32'hFFFF0F0C, 32'h00000F0C},
    {3'd6, 32'h00003FFF, 32'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rchk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr = a; #0.2;
    chk(tag, rdata, exp);
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    waitn(3); rst_n = 1'b1; waitn(1);
    // R1 reset state
    for (int i = 0; i < 8; i++) rchk(i[2:0], 32'h0, "R1 reset readback");
    chk("R1 wdt_rst low", {31'b0, wdt_rst}, 32'h0);

    // R2 register table
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rchk(VEC[i][66:64], VEC[i][31:0], "R2 readback");
    end

    // R3 prescaler and run conditions
    wr(3'd4, 32'hFFFFFFFF); wr(3'd5, 32'hFFFFFFFF);
    wr(3'd2, 0); wr(3'd3, 0);
    wr(3'd1, 32'h00800000);
    wr(3'd0, 32'h00000303);
    waitn(40); rchk(3'd2, 32'd10, "R3 div4 count");
    wr(3'd0, 32'h00000300);
    waitn(10); rchk(3'd2, 32'd10, "R3 held with halves in reset");
    wr(3'd2, 0);
    wr(3'd0, 32'h00000F03);
    waitn(64); rchk(3'd2, 32'd4, "R3 div16 count");
    wr(3'd1, 32'h00400000);
    waitn(20); rchk(3'd2, 32'd4, "R3 held when run field not 2");
    wr(3'd0, 0); wr(3'd1, 32'h00800000);

    // R4 carry and 64-bit compare
    wr(3'd4, 0); wr(3'd5, 1);
    wr(3'd2, 32'hFFFFFFFE); wr(3'd3, 0);
    wr(3'd0, 32'h00000003);
    waitn(2);
    rchk(3'd2, 32'h0, "R4 carry low");
    rchk(3'd3, 32'h1, "R4 carry high");
    waitn(1);
    rchk(3'd3, 32'h0, "R4 wrap high");
    waitn(1);
    rchk(3'd2, 32'h1, "R4 after wrap");
    wr(3'd0, 0);
    wr(3'd4, 5); wr(3'd5, 0); wr(3'd2, 0); wr(3'd3, 0);
    wr(3'd0, 32'h00000003);
    waitn(6); rchk(3'd2, 32'h0, "R4 wrap at period 5");
    waitn(1); rchk(3'd2, 32'h1, "R4 restart");
    chk("R10 no pulse with watchdog off", pulses, 0);
    wr(3'd0, 0);

    // R5 timeout
    wr(3'd4, 20); wr(3'd2, 0); wr(3'd3, 0);
    wr(3'd6, 32'hA5C64000); wr(3'd6, 32'hDA7E4000);
    rchk(3'd6, 32'h00004000, "R7 enable set");
    wr(3'd0, 32'h0000000B);
    waitn(20);
    chk("R5 no pulse before match", {31'b0, wdt_rst}, 0);
    rchk(3'd2, 32'd20, "R5 count at period");
    waitn(1);
    chk("R5 pulse high", {31'b0, wdt_rst}, 1);
    rchk(3'd2, 32'd0, "R5 count wrapped");
    waitn(1);
    chk("R5 pulse one cycle", {31'b0, wdt_rst}, 0);
    rchk(3'd6, 32'h0000C000, "R5 flag set");
    chk("R5 single pulse", pulses, 1);
    wr(3'd0, 32'h00000008);

    // R6 flag clear, enable sticky
    wr(3'd6, 32'h00008000);
    rchk(3'd6, 32'h00004000, "R6 flag cleared enable kept");

    // R8 bad sequences, R7 good service
    wr(3'd2, 7); wr(3'd3, 3);
    wr(3'd6, 32'hDA7E4000);
    rchk(3'd2, 32'd7, "R8 service without arm");
    wr(3'd6, 32'hA5C64000); wr(3'd6, 32'h12344000); wr(3'd6, 32'hDA7E4000);
    rchk(3'd2, 32'd7, "R8 wrong key between");
    wr(3'd6, 32'hA5C60000); wr(3'd6, 32'hDA7E4000);
    rchk(3'd2, 32'd7, "R8 arm without bit 14");
    wr(3'd6, 32'hA5C64000); wr(3'd6, 32'hDA7E0000);
    rchk(3'd2, 32'd7, "R8 service without bit 14");
    wr(3'd6, 32'hA5C64000); wr(3'd6, 32'hDA7E4000);
    rchk(3'd2, 32'd0, "R7 service clears low");
    rchk(3'd3, 32'd0, "R7 service clears high");

    // R9 regular servicing
    wr(3'd0, 32'h0000000B);
    for (int i = 0; i < 6; i++) begin
      waitn(8);
      wr(3'd6, 32'hA5C64000); wr(3'd6, 32'hDA7E4000);
    end
    chk("R9 no new pulse", pulses, 1);
    rchk(3'd6, 32'h00004000, "R9 flag clear");
    wr(3'd0, 0);

    // R10 match outside watchdog mode
    wr(3'd2, 0); wr(3'd3, 0);
    wr(3'd0, 32'h00000003);
    waitn(30);
    rchk(3'd2, 32'd9, "R10 wrapped count");
    chk("R10 no pulse in mode 0", pulses, 1);
    rchk(3'd6, 32'h00004000, "R10 flag clear");

    // R1 reset mid-run clears enable
    @(negedge clk); rst_n = 1'b0; waitn(2); rst_n = 1'b1; waitn(1);
    rchk(3'd6, 32'h0, "R1 enable cleared by reset");
    rchk(3'd2, 32'h0, "R1 count cleared by reset");
    finish_run();
  end
endmodule